// File: doc/BRIEF.md
# Banked Management Register Bus Port

This block is an 8-bit slave port for a small processor that reaches a set of banked management registers. The processor drives a chip select, a command/data select, separate read and write strobes and an 8-bit data bus. The block answers with a ready handshake, a data-bus enable and an active-low interrupt. All strobes are asynchronous. They pass through two-flop synchronizers, and every action is taken on a detected strobe edge in the internal clock domain.

Writes to the command port pick where data-port accesses go. One prefix chooses a register bank and another chooses an attribute register inside the current bank. Registers are wider than the bus, so they are moved one byte at a time, least significant byte first. A write only reaches the register after its last byte arrives. A read returns bytes from a snapshot taken when the first byte is read. A small demo register set is included: a 4-byte control register, a 2-byte interrupt mask, a 2-byte clear-on-read event status (set by an event input) and a 1-byte scratch register in bank 1.

Top module: `mgmt_bus_port`

## Requirements
- R1: An access starts only while `cs_n` is low together with `rd_n` or `wr_n`. A strobe given while `cs_n` is high never drops `rdy` and changes no register.
- R2: `rdy` is high out of reset and while idle. It goes low for exactly one clock after a strobe's leading edge is detected and then returns high.
- R3: A command-port write with bits [7:5] = 000 selects bank [4:0]. With bits [7:5] = 111 it selects attribute register [4:0]. Any other prefix leaves both selections unchanged. Command-port reads return 0x00.
- R4: Map: bank 0 attribute 0 is the 4-byte control register, attribute 1 is the 2-byte mask, attribute 2 is the 2-byte status. Bank 1 attribute 0 is the 1-byte scratch register. Data bytes are written least significant first. The register takes the new value only when its final byte is written. Unmapped locations read 0x00 and ignore writes.
- R5: A command write after a partial multi-byte write discards the staged bytes. The register keeps its old value, and the next data access starts at byte 0.
- R6: A multi-byte read returns bytes least significant first. All bytes come from a copy captured when byte 0 is read, so later changes do not show in bytes 1..N-1.
- R7: Each set bit of `evt_in` sets the matching status bit. Reading status byte 0 clears the whole status register. An event arriving in the same cycle as that clear survives it.
- R8: `irq_n` is high after reset and whenever status AND mask is zero. It is low while any masked-in status bit is set. Reading the status returns it high.
- R9: `data_oe` is high only during a synchronized read strobe. It falls within three clocks of the strobe being released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cmd_sel | input | 1 | 1 = command port, 0 = data port |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data taken at its release |
| data_in | input | 8 | Write data from the processor |
| evt_in | input | 16 | Event pulses that set status bits |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Read data bus enable |
| rdy | output | 1 | Ready handshake, low while busy |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The two functions that can land in one cycle are the whole-register clear caused by reading status byte 0 and the setting of a status bit by `evt_in`. The bench holds an event bit high across an entire status read, so it is certainly present at the clear edge. It then expects that bit in the returned byte and still set on the next read, while bits that were not refreshed must be gone. A second case raises an event between the two byte reads of one status access. That byte must come from the old snapshot while the live register picks up the new bit.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    localparam int DW        = 8;
    localparam int SEL_W     = 5;
    localparam int MAX_BYTES = 4;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int LEN_W     = IDX_W + 1;
    localparam int REG_W     = MAX_BYTES * DW;
    localparam int EVT_W     = 16;

    typedef struct packed {
        logic [SEL_W-1:0] bank;
        logic [SEL_W-1:0] attr;
    } sel_t;

    typedef enum logic [1:0] {CMD_BANK, CMD_ATTR, CMD_NONE} cmd_kind_e;

    typedef enum logic [2:0] {REG_CTRL, REG_MASK, REG_STAT, REG_SCR, REG_NONE} reg_id_e;

    function automatic cmd_kind_e decode_cmd(input logic [DW-1:0] b);
        if (b[7:5] == 3'b000)      return CMD_BANK;
        else if (b[7:5] == 3'b111) return CMD_ATTR;
        else                       return CMD_NONE;
    endfunction

    function automatic reg_id_e reg_lookup(input sel_t s);
        if (s.bank == '0) begin
            case (s.attr)
                5'd0:    return REG_CTRL;
                5'd1:    return REG_MASK;
                5'd2:    return REG_STAT;
                default: return REG_NONE;
            endcase
        end else if (s.bank == 5'd1 && s.attr == '0) begin
            return REG_SCR;
        end
        return REG_NONE;
    endfunction

    function automatic logic [LEN_W-1:0] reg_len(input reg_id_e r);
        case (r)
            REG_CTRL:          return LEN_W'(MAX_BYTES);
            REG_MASK, REG_STAT: return LEN_W'(EVT_W / DW);
            default:           return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= req[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i]  = s2;
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/mbp_regfile.sv
module mbp_regfile
    import mbp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_id_e              reg_id,
    input  logic                 wr_stage,
    input  logic                 wr_commit,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wr_byte,
    input  logic                 rd_first,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [EVT_W-1:0]     evt_in,
    output logic [DW-1:0]        rd_byte,
    output logic [EVT_W-1:0]     mask_q,
    output logic [EVT_W-1:0]     stat_q
);
    logic [REG_W-1:0] ctrl_q;
    logic [DW-1:0]    scr_q;
    logic [REG_W-1:0] stage_q;
    logic [REG_W-1:0] stage_next;
    logic [REG_W-1:0] snap_q;
    logic [REG_W-1:0] cur_val;
    logic             stat_clr;

    always_comb begin
        case (reg_id)
            REG_CTRL: cur_val = ctrl_q;
            REG_MASK: cur_val = REG_W'(mask_q);
            REG_STAT: cur_val = REG_W'(stat_q);
            REG_SCR:  cur_val = REG_W'(scr_q);
            default:  cur_val = '0;
        endcase
    end

    always_comb begin
        stage_next = stage_q;
        stage_next[wr_idx*DW +: DW] = wr_byte;
    end

    assign rd_byte  = rd_first ? cur_val[DW-1:0] : snap_q[rd_idx*DW +: DW];
    assign stat_clr = rd_first && (reg_id == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            scr_q   <= '0;
            mask_q  <= '0;
            stat_q  <= '0;
            stage_q <= '0;
            snap_q  <= '0;
        end else begin
            if (wr_stage) stage_q <= stage_next;
            if (rd_first) snap_q  <= cur_val;
            if (wr_stage && wr_commit) begin
                case (reg_id)
                    REG_CTRL: ctrl_q <= stage_next;
                    REG_MASK: mask_q <= stage_next[EVT_W-1:0];
                    REG_SCR:  scr_q  <= stage_next[DW-1:0];
                    default:  ;
                endcase
            end
            stat_q <= (stat_clr ? '0 : stat_q) | evt_in;
        end
    end
endmodule

// File: rtl/mgmt_bus_port.sv
module mgmt_bus_port
    import mbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             cmd_sel,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [DW-1:0]    data_in,
    input  logic [EVT_W-1:0] evt_in,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             rdy,
    output logic             irq_n
);
    localparam int RD = 0;
    localparam int WR = 1;

    logic [1:0]       req, lvl, rise, fall;
    logic [DW-1:0]    wr_data_q;
    logic             wr_cmd_q;
    sel_t             sel_q;
    logic [IDX_W-1:0] idx_q;
    logic             seq_wr_q;
    reg_id_e          reg_id;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] wr_eff, rd_eff;
    logic             wr_last, rd_last;
    logic             cmd_fire, dwr_fire, drd_fire;
    logic [DW-1:0]    rd_byte;
    logic [EVT_W-1:0] mask_q, stat_q;
    logic [DW-1:0]    data_out_q;
    logic             rdy_q;

    assign req[RD] = ~cs_n & ~rd_n;
    assign req[WR] = ~cs_n & ~wr_n;

    mbp_sync #(.W(2)) sync_i (
        .clk (clk), .rst (rst), .req (req),
        .lvl (lvl), .rise (rise), .fall (fall)
    );

    assign reg_id  = reg_lookup(sel_q);
    assign len     = reg_len(reg_id);
    assign wr_eff  = seq_wr_q ? idx_q : '0;
    assign rd_eff  = seq_wr_q ? '0 : idx_q;
    assign wr_last = ({1'b0, wr_eff} == len - LEN_W'(1));
    assign rd_last = ({1'b0, rd_eff} == len - LEN_W'(1));

    assign cmd_fire = fall[WR] &  wr_cmd_q;
    assign dwr_fire = fall[WR] & ~wr_cmd_q;
    assign drd_fire = rise[RD] & ~cmd_sel & ~fall[WR];

    mbp_regfile rf_i (
        .clk       (clk),
        .rst       (rst),
        .reg_id    (reg_id),
        .wr_stage  (dwr_fire),
        .wr_commit (wr_last),
        .wr_idx    (wr_eff),
        .wr_byte   (wr_data_q),
        .rd_first  (drd_fire && rd_eff == '0),
        .rd_idx    (rd_eff),
        .evt_in    (evt_in),
        .rd_byte   (rd_byte),
        .mask_q    (mask_q),
        .stat_q    (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_data_q  <= '0;
            wr_cmd_q   <= 1'b0;
            sel_q      <= '0;
            idx_q      <= '0;
            seq_wr_q   <= 1'b0;
            data_out_q <= '0;
            rdy_q      <= 1'b1;
        end else begin
            if (lvl[WR]) begin
                wr_data_q <= data_in;
                wr_cmd_q  <= cmd_sel;
            end
            rdy_q <= ~(rise[RD] | rise[WR]);
            if (cmd_fire) begin
                idx_q <= '0;
                case (decode_cmd(wr_data_q))
                    CMD_BANK: sel_q.bank <= wr_data_q[SEL_W-1:0];
                    CMD_ATTR: sel_q.attr <= wr_data_q[SEL_W-1:0];
                    default:  ;
                endcase
            end else if (dwr_fire) begin
                seq_wr_q <= 1'b1;
                idx_q    <= wr_last ? '0 : wr_eff + IDX_W'(1);
            end else if (drd_fire) begin
                seq_wr_q <= 1'b0;
                idx_q    <= rd_last ? '0 : rd_eff + IDX_W'(1);
            end
            if (rise[RD]) data_out_q <= cmd_sel ? '0 : rd_byte;
        end
    end

    assign data_out = data_out_q;
    assign data_oe  = lvl[RD];
    assign rdy      = rdy_q;
    assign irq_n    = ~|(stat_q & mask_q);

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker
    import mbp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             rd_n,
    input logic             rdy,
    input logic             data_oe,
    input logic             irq_n,
    input logic [EVT_W-1:0] mask_q,
    input logic             cmd_fire,
    input logic [DW-1:0]    cmd_byte,
    input sel_t             sel_q
);
    logic rd_req;
    assign rd_req = ~cs_n & ~rd_n;

    // R2
    a_r2_rdy_single_low: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> rdy);

    // R1
    a_r1_no_access_without_cs: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> rdy);

    // R3
    a_r3_bad_prefix_keeps_sel: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && cmd_byte[7:5] != 3'b000 && cmd_byte[7:5] != 3'b111) |=> $stable(sel_q));

    // R8
    a_r8_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> irq_n);

    // R9
    a_r9_oe_follows_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_req, 1) && !$past(rd_req, 2) && !$past(rd_req, 3)) |-> !data_oe);
endmodule

bind mgmt_bus_port mbp_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .rdy      (rdy),
    .data_oe  (data_oe),
    .irq_n    (irq_n),
    .mask_q   (mask_q),
    .cmd_fire (cmd_fire),
    .cmd_byte (wr_data_q),
    .sel_q    (sel_q)
);

// File: tb/mgmt_bus_port_tb_top.sv
module mgmt_bus_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b0;
    logic        cmd_sel = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  data_in = '0;
    logic [15:0] evt_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        rdy;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] ctrl_m = '0;
    logic [15:0] mask_m = '0;
    logic [15:0] stat_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_bus_port dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_sel(cmd_sel), .rd_n(rd_n),
        .wr_n(wr_n), .data_in(data_in), .evt_in(evt_in), .data_out(data_out),
        .data_oe(data_oe), .rdy(rdy), .irq_n(irq_n)
    );

    function automatic logic [7:0] byte_of(input logic [31:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    function automatic logic exp_irq_n(input logic [15:0] s, input logic [15:0] m);
        return ~|(s & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic handshake(input string req);
        int n;
        n = 0;
        while (rdy !== 1'b0 && n < 20) begin @(negedge clk); n++; end
        while (rdy !== 1'b1 && n < 40) begin @(negedge clk); n++; end
        check(req, (n < 40) ? 32'd1 : 32'd0, 32'd1);
    endtask

    task automatic wr_acc(input logic c, input logic [7:0] d);
        @(negedge clk);
        cmd_sel = c; data_in = d; wr_n = 1'b0;
        handshake("R2");
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_acc(input logic c, output logic [7:0] d);
        @(negedge clk);
        cmd_sel = c; rd_n = 1'b0;
        handshake("R2");
        d = data_out;
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic select(input logic [4:0] bank, input logic [4:0] attr);
        wr_acc(1'b1, {3'b000, bank});
        wr_acc(1'b1, {3'b111, attr});
    endtask

    task automatic write_n(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) wr_acc(1'b0, byte_of(v, i));
    endtask

    task automatic read_n(input int n, output logic [31:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < n; i++) begin
            rd_acc(1'b0, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge clk); evt_in = v;
        @(negedge clk); evt_in = '0;
        stat_m = stat_m | v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        int lowseen;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 rdy at reset", {31'd0, rdy}, 32'd1);
        check("R8 irq at reset", {31'd0, irq_n}, 32'd1);
        check("R9 oe at reset", {31'd0, data_oe}, 32'd0);

        // R4 / R6: full control write and readback
        select(5'd0, 5'd0);
        write_n(32'h4433_2211, 4); ctrl_m = 32'h4433_2211;
        read_n(4, v);
        check("R4 ctrl write", v, ctrl_m);

        // R9: data_oe during and after read
        @(negedge clk); cmd_sel = 1'b0; rd_n = 1'b0;
        handshake("R2");
        check("R9 oe during read", {31'd0, data_oe}, 32'd1);
        check("R6 first byte lsb", {24'd0, data_out}, {24'd0, byte_of(ctrl_m, 0)});
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 oe after read", {31'd0, data_oe}, 32'd0);
        wr_acc(1'b1, 8'hE0);

        // R5: partial write discarded by command
        write_n(32'hDEAD_BEEF, 2);
        wr_acc(1'b1, 8'hE0);
        read_n(4, v);
        check("R5 partial discarded", v, ctrl_m);

        // R3: bad prefix and command read
        wr_acc(1'b1, 8'h41);
        wr_acc(1'b1, 8'hA2);
        read_n(4, v);
        check("R3 bad prefix ignored", v, ctrl_m);
        rd_acc(1'b1, b);
        check("R3 cmd read zero", {24'd0, b}, 32'd0);

        // R3 / R4: scratch in bank 1, unmapped in bank 2
        select(5'd1, 5'd0);
        write_n(32'h0000_005A, 1);
        read_n(1, v);
        check("R4 scratch", v, 32'h5A);
        select(5'd2, 5'd0);
        write_n(32'h0000_0077, 1);
        read_n(1, v);
        check("R4 unmapped reads zero", v, 32'h0);
        select(5'd0, 5'd0);
        read_n(4, v);
        check("R3 bank switch back", v, ctrl_m);

        // R1: strobe with cs_n high
        wr_acc(1'b1, 8'hE1);
        @(negedge clk); cs_n = 1'b1; cmd_sel = 1'b0; data_in = 8'hFF; wr_n = 1'b0;
        lowseen = 0;
        repeat (8) begin @(negedge clk); if (rdy !== 1'b1) lowseen = 1; end
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        check("R1 rdy held without cs", lowseen, 0);
        read_n(2, v);
        check("R1 mask unchanged", v, {16'd0, mask_m});

        // R8: masked events
        pulse_evt(16'h0300);
        @(negedge clk);
        check("R8 masked irq off", {31'd0, irq_n}, {31'd0, exp_irq_n(stat_m, mask_m)});
        write_n(32'h0000_0101, 2); mask_m = 16'h0101;
        @(negedge clk);
        check("R8 irq on", {31'd0, irq_n}, {31'd0, exp_irq_n(stat_m, mask_m)});

        // R7: clear-on-read
        wr_acc(1'b1, 8'hE2);
        read_n(2, v);
        check("R7 status value", v, {16'd0, stat_m});
        stat_m = '0;
        @(negedge clk);
        check("R8 irq cleared by read", {31'd0, irq_n}, 32'd1);
        read_n(2, v);
        check("R7 status cleared", v, 32'd0);

        // R6 / R7: snapshot between bytes
        pulse_evt(16'h0101);
        rd_acc(1'b0, b);
        check("R7 byte0", {24'd0, b}, 32'h01);
        stat_m = '0;
        pulse_evt(16'h0200);
        rd_acc(1'b0, b);
        check("R6 byte1 from snapshot", {24'd0, b}, 32'h01);
        read_n(2, v);
        check("R7 live picked new event", v, 32'h0200);
        stat_m = '0;

        // R7: event held across clear
        pulse_evt(16'h0010);
        @(negedge clk); evt_in = 16'h0004;
        read_n(2, v);
        @(negedge clk); evt_in = '0;
        check("R7 read with held event", v, 32'h0014);
        read_n(2, v);
        check("R7 held event survives clear", v, 32'h0004);
        stat_m = '0;

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [31:0] r;
            logic [15:0] e, m;
            int n;
            r = $urandom; n = $urandom_range(1, 4);
            select(5'd0, 5'd0);
            write_n(r, n);
            if (n == 4) ctrl_m = r;
            wr_acc(1'b1, 8'hE0);
            read_n(4, v);
            check("R4 R5 random ctrl", v, ctrl_m);
            m = 16'($urandom); e = 16'($urandom);
            wr_acc(1'b1, 8'hE1);
            write_n({16'd0, m}, 2); mask_m = m;
            pulse_evt(e);
            @(negedge clk);
            check("R8 random irq", {31'd0, irq_n}, {31'd0, exp_irq_n(stat_m, mask_m)});
            wr_acc(1'b1, 8'hE2);
            read_n(2, v);
            check("R7 random status", v, {16'd0, stat_m});
            stat_m = '0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule